// File: doc/BRIEF.md
# FIFO Almost-Flag Threshold Register File

This block keeps the two thresholds that a FIFO's flag logic compares its fill level against: the almost-empty margin and the almost-full margin. Software reaches them through the FIFO's own data buses, not through a separate register port. While the configuration strobe `cfg_ld` is high, a write-enable cycle stores the low bits of the write data bus into a threshold register. A read-enable cycle under the same strobe returns a threshold on the low bits of the read data bus.

Two independent one-bit sequencers pick which register each access reaches. One serves the write side and one serves the read side. Each starts at the almost-empty register and alternates with every access of its own kind, so two writes set both thresholds and two reads return both. While the strobe is high the FIFO core must not push or pop. The block therefore gives the core qualified push and pop enables, which are low during configuration accesses.

The write and read ports share one clock, which is the coincident-clock use of the FIFO. After reset both thresholds take a default that depends on the FIFO depth: 31 for 256 words or fewer, 63 for 512 words, and 127 for anything deeper.

Top module: `ofs_flag_regs`

## Requirements
- R1: While `rst` is high at a rising edge, both thresholds take the depth default (127 for the default `ADDR_W`=10), `rd_data` becomes 0, and both sequencers return to the almost-empty register.
- R2: A rising edge with `cfg_ld` and `wr_en` both high stores `wr_data[ADDR_W-1:0]` into the register chosen by the write sequencer. The new value appears on `ae_thresh` or `af_thresh` after that edge.
- R3: The write sequencer selects almost-empty for the first configuration write after reset, almost-full for the second, and then keeps alternating.
- R4: A rising edge with `cfg_ld` and `rd_en` both high loads `rd_data` with the register chosen by the read sequencer. The value is zero-extended, so `rd_data[DATA_W-1:ADDR_W]` is 0.
- R5: The read sequencer starts at almost-empty after reset and alternates on each configuration read, independently of the write sequencer.
- R6: A write-enable cycle with `cfg_ld` low changes neither threshold nor the write sequencer, and `fifo_push` is high during it.
- R7: A read-enable cycle with `cfg_ld` low leaves `rd_data` and the read sequencer unchanged, and `fifo_pop` is high during it.
- R8: While `cfg_ld` is high, `fifo_push` and `fifo_pop` are both low, whatever `wr_en` and `rd_en` are.
- R9: Bits `wr_data[DATA_W-1:ADDR_W]` have no effect on the stored threshold, so written values are masked to the address width.
- R10: If a configuration read and a configuration write reach the same register at the same edge, the read returns the value held before that edge.
- R11: A reset in the middle of a write or read sequence puts the next access of each kind back on the almost-empty register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared write/read clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ld | input | 1 | Configuration strobe, routes accesses to the threshold registers |
| wr_en | input | 1 | Write enable of the FIFO write port |
| rd_en | input | 1 | Read enable of the FIFO read port |
| wr_data | input | DATA_W | FIFO write data bus; low ADDR_W bits carry a threshold |
| rd_data | output | DATA_W | Threshold readback, registered, holds between reads |
| fifo_push | output | 1 | Qualified push enable for the FIFO core |
| fifo_pop | output | 1 | Qualified pop enable for the FIFO core |
| ae_thresh | output | ADDR_W | Almost-empty threshold to the flag comparator |
| af_thresh | output | ADDR_W | Almost-full threshold to the flag comparator |

## Verification
The directed part writes two distinct values and checks that they reach the two outputs in order. It then reads them back twice, which shows whether each sequencer alternates or stays on one register. A write whose upper data bits are all ones, and a write carrying a full-range value, separate correct masking from a truncation that lands in the wrong place.

A cycle that reads and writes the same register at once shows whether the readback is taken before or after the update. A reset placed after an odd number of accesses exposes a sequencer that does not return to almost-empty. Random cycles then mix the strobe with every enable combination. These show whether plain FIFO traffic ever disturbs the thresholds, the readback bus or the push and pop gating.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  // depth-dependent default margin
  function automatic int unsigned default_margin(input int unsigned aw);
    if (aw <= 8)
      return 31;
    else if (aw == 9)
      return 63;
    else
      return 127;
  endfunction

endpackage

// File: rtl/ofs_seq.sv
module ofs_seq
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output ofs_sel_e sel
);

  always_ff @(posedge clk) begin
    if (rst)
      sel <= SEL_AE;
    else if (step)
      sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
  end

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  ofs_sel_e          wsel,
  input  logic [DATA_W-1:0] wval,
  output logic [ADDR_W-1:0] ae_val,
  output logic [ADDR_W-1:0] af_val
);

  localparam int NREG = 2;
  localparam logic [ADDR_W-1:0] DEF = ADDR_W'(default_margin(ADDR_W));

  logic [ADDR_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= DEF;
      else if (we && (int'(wsel) == i))
        regs[i] <= ADDR_W'(wval);
    end
  end

  assign ae_val = regs[SEL_AE];
  assign af_val = regs[SEL_AF];

endmodule

// File: rtl/ofs_rdport.sv
module ofs_rdport
  import ofs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  ofs_sel_e          rsel,
  input  logic [ADDR_W-1:0] ae_val,
  input  logic [ADDR_W-1:0] af_val,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pick;

  always_comb pick = (rsel == SEL_AF) ? af_val : ae_val;

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= {{PAD_W{1'b0}}, pick};
  end

endmodule

// File: rtl/ofs_flag_regs.sv
module ofs_flag_regs
  import ofs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ld,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic [ADDR_W-1:0] ae_thresh,
  output logic [ADDR_W-1:0] af_thresh
);

  logic     cfg_wr, cfg_rd;
  ofs_sel_e wr_sel, rd_sel;

  assign cfg_wr    = cfg_ld & wr_en;
  assign cfg_rd    = cfg_ld & rd_en;
  assign fifo_push = wr_en & ~cfg_ld;
  assign fifo_pop  = rd_en & ~cfg_ld;

  ofs_seq u_wseq (.clk(clk), .rst(rst), .step(cfg_wr), .sel(wr_sel));
  ofs_seq u_rseq (.clk(clk), .rst(rst), .step(cfg_rd), .sel(rd_sel));

  ofs_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_wr), .wsel(wr_sel), .wval(wr_data),
    .ae_val(ae_thresh), .af_val(af_thresh)
  );

  ofs_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .re(cfg_rd), .rsel(rd_sel),
    .ae_val(ae_thresh), .af_val(af_thresh), .rdata(rd_data)
  );

endmodule

// File: rtl/ofs_flag_regs_chk.sv
module ofs_flag_regs_chk
  import ofs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ld,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] ae_thresh,
  input logic [ADDR_W-1:0] af_thresh,
  input ofs_sel_e          wr_sel,
  input ofs_sel_e          rd_sel
);

  localparam logic [ADDR_W-1:0] DEF = ADDR_W'(default_margin(ADDR_W));

  // R1
  reset_default_chk: assert property (@(posedge clk)
    rst |=> (ae_thresh == DEF && af_thresh == DEF && rd_data == '0));

  // R3
  wr_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_ld && wr_en) |=> wr_sel != $past(wr_sel));

  // R5
  rd_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_ld && rd_en) |=> rd_sel != $past(rd_sel));

  // R4
  rd_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_ld && rd_en) |=> rd_data[DATA_W-1:ADDR_W] == '0);

  // R6
  thresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ld && wr_en) |=> ($stable(ae_thresh) && $stable(af_thresh)));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ld && rd_en) |=> $stable(rd_data));

endmodule

bind ofs_flag_regs ofs_flag_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ofs_flag_regs.sv
`timescale 1ns/1ps
module tb_ofs_flag_regs;

  localparam int AW  = 10;
  localparam int DW  = 18;
  localparam int DEF = 127;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          fifo_push, fifo_pop;
  logic [AW-1:0] ae_thresh, af_thresh;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  int unsigned m_ae, m_af, m_rd;
  bit          m_wp, m_rp;

  always #2.5 clk = ~clk;

  ofs_flag_regs #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cfg_ld(cfg_ld), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .ae_thresh(ae_thresh), .af_thresh(af_thresh)
  );

  function automatic int unsigned mask_aw(input logic [DW-1:0] d);
    return int'(d) & ((1 << AW) - 1);
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ae = DEF; m_af = DEF; m_rd = 0; m_wp = 0; m_rp = 0;
  endtask

  // one cycle: drive, check gating, clock, check state
  task automatic cyc(input bit ld, input bit we, input bit re, input logic [DW-1:0] d);
    cfg_ld = ld; wr_en = we; rd_en = re; wr_data = d;
    #1;
    check("R6 R8 push", fifo_push, (we && !ld) ? 1 : 0);
    check("R7 R8 pop",  fifo_pop,  (re && !ld) ? 1 : 0);
    // read sees pre-write value (R10)
    if (ld && re) begin
      m_rd = m_rp ? m_af : m_ae;
      m_rp = ~m_rp;
    end
    if (ld && we) begin
      if (m_wp) m_af = mask_aw(d); else m_ae = mask_aw(d);
      m_wp = ~m_wp;
    end
    @(posedge clk); #1;
    check((ld && we) ? "R2 R3 R9 ae" : "R6 ae", ae_thresh, m_ae);
    check((ld && we) ? "R2 R3 R9 af" : "R6 af", af_thresh, m_af);
    check((ld && re) ? "R4 R5 R10 rd" : "R7 rd", rd_data, m_rd);
  endtask

  task automatic do_reset();
    rst = 1'b1; cfg_ld = 0; wr_en = 0; rd_en = 0;
    @(posedge clk); #1;
    model_reset();
    rst = 1'b0;
    check("R1 R11 ae", ae_thresh, DEF);
    check("R1 R11 af", af_thresh, DEF);
    check("R1 rd", rd_data, 0);
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(posedge clk); #1;
    do_reset();
    // R2 R3: two writes land on AE then AF
    cyc(1, 1, 0, 18'h00005);
    cyc(1, 1, 0, 18'h00123);
    // R4 R5: read back in order, twice
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, '0);
    // R9: upper bits set, masking
    cyc(1, 1, 0, 18'h3FC11);
    cyc(1, 1, 0, 18'h3FFFF);
    // R6 R7: plain FIFO traffic
    cyc(0, 1, 1, 18'h2AAAA);
    cyc(0, 1, 0, 18'h00001);
    // R10: same register read and written at once (both pointers at AE)
    cyc(1, 1, 1, 18'h00077);
    cyc(1, 1, 1, 18'h00088);
    // R11: reset after an odd number of accesses
    cyc(1, 1, 1, 18'h00042);
    do_reset();
    cyc(1, 1, 0, 18'h00099);
    cyc(1, 0, 1, '0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      cyc(($urandom % 3) == 0, $urandom[0], $urandom[0], d);
      if (($urandom % 500) == 0) do_reset();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule